// File: doc/BRIEF.md
# Shadowed Boot-ROM Address Decoder with Wait-State Generation

This block sits between a small CPU bus and its memories. It steers each bus access to a slow boot ROM, to DRAM, or to a two-bit control register, and it holds the access open for the right number of wait states before it signals completion. The top 64 KiB of the 20-bit address space (0xF0000 to 0xFFFFF) is a window that the boot ROM occupies. Ordinary DRAM lies underneath that window at the same addresses. The decoder keeps that DRAM hidden until software asks for it. No extra storage is used for the shadow copy.

A control register at I/O address 0x0F8 holds two bits. The shadow-select bit decides which device answers reads in the window: the ROM, or the DRAM under it. The shadow write-enable bit decides whether writes into the window reach that DRAM. Boot code builds the shadow copy in four steps. First it reads the ROM and stores the data in low DRAM while the ROM is visible. Next it sets the select bit. Then it copies the low-memory data into the window, so the data lands in the hidden DRAM. Finally it clears write-enable to protect the copy.

The bus uses a valid/ready handshake with one request outstanding. The master raises `req_valid` and holds the request fields stable until it sees `req_ready` high at a clock edge. `req_ready` is a single-cycle completion pulse, which gives back-pressure through the wait states. The master may drop `req_valid` or present a new request after that edge. The block starts the next access no earlier than the cycle after the ready pulse.

Top module: `bootwin_decoder`

## Requirements
- R1: After reset, the select bit is 0 and the write-enable bit is 1. With no request present, `rom_sel`, `dram_sel`, `mem_we` and `req_ready` are all low.
- R2: While select is 0, reads in the window 0xF0000..0xFFFFF assert `rom_sel` only. They take 2 wait states when `cfg_rom_slow`=0 and 3 when it is 1. The ROM never gets `mem_we`.
- R3: Memory accesses outside the window, reads and writes alike, go to DRAM (`dram_sel`). They take 0 wait states when `cfg_dram_slow`=0 and 1 when it is 1.
- R4: While select is 1, window reads assert `dram_sel` and never `rom_sel`, and they return the DRAM contents with DRAM wait states.
- R5: While write-enable is 1, window writes go to DRAM with DRAM wait states, whatever the select bit is.
- R6: While write-enable is 0, window writes assert neither select nor `mem_we`, complete after the DRAM wait states, and leave the DRAM contents unchanged.
- R7: An I/O access (`req_io`=1) to address 0x0F8 reads or writes the control register: data bit 0 is select and bit 1 is write-enable, and other read bits are 0. It takes 0 wait states. An I/O access to any other address selects nothing, reads 0 and changes nothing.
- R8: An access starts at the first clock edge where `req_valid` is high and the block is idle. Its device select stays high through the following cycles. `req_ready` is high for exactly one cycle, the (W+1)-th cycle after the start edge, where W is the wait-state count. For a DRAM write, `mem_we` is high only in that ready cycle.
- R9: Each access produces exactly one ready pulse and at most one write strobe. In the cycle after the ready pulse with `req_valid` low, no select and no ready are asserted.
- R10: The wait-state configuration inputs are sampled when the access starts. A change during the access does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rom_slow | input | 1 | ROM wait states: 0 selects 2, 1 selects 3 |
| cfg_dram_slow | input | 1 | DRAM wait states: 0 selects 0, 1 selects 1 |
| req_valid | input | 1 | Request present; held until ready |
| req_ready | output | 1 | One-cycle completion pulse |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid in the ready cycle |
| rom_sel | output | 1 | Boot ROM chip select |
| dram_sel | output | 1 | DRAM select |
| mem_we | output | 1 | DRAM write strobe |
| mem_wdata | output | 8 | Write data to the memories |
| mem_rdata | input | 8 | Read data from the selected memory |

## Verification
The bench runs the four-step load sequence from start to finish and then reads the window back with select set. A decoder that wrote to the ROM, or that pointed the copy at other storage, would return ROM-like or stale bytes there. Writes with protection off are checked by reading the same locations afterwards. A design that let a strobe through would return the overwritten data. A write made with select 0 is shown to land in the hidden DRAM, while ROM data still appears until select flips. Every access has its ready cycle counted against 0, 1, 2 and 3 wait states, including a configuration change in the middle of an access. A design that sampled the configuration late, or that let ready run one cycle early or late, would show the wrong count.

// File: rtl/bw_pkg.sv
`timescale 1ns/1ps
package bw_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_DRAM = 2'd2,
    TGT_CTRL = 2'd3
  } bw_target_e;

  localparam int ROM_WS_FAST  = 2;
  localparam int ROM_WS_SLOW  = 3;
  localparam int DRAM_WS_FAST = 0;
  localparam int DRAM_WS_SLOW = 1;
  localparam int IO_WS        = 0;
  localparam int CTRL_BITS    = 2;
endpackage

// File: rtl/bw_target_decode.sv
`timescale 1ns/1ps
module bw_target_decode
  import bw_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int WIN_TAG_W = 4,
  parameter logic [WIN_TAG_W-1:0] WIN_TAG = '1,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 20'h000F8,
  parameter int CNT_W     = 2
) (
  input  logic              io,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              shadow_sel,
  input  logic              shadow_we,
  input  logic              rom_slow,
  input  logic              dram_slow,
  output bw_target_e        target,
  output logic [CNT_W-1:0]  waits,
  output logic              in_window
);
  localparam int WIN_LSB = ADDR_W - WIN_TAG_W;

  logic [CNT_W-1:0] rom_ws;
  logic [CNT_W-1:0] dram_ws;

  assign in_window = !io && (addr[ADDR_W-1:WIN_LSB] == WIN_TAG);
  assign rom_ws    = rom_slow  ? CNT_W'(ROM_WS_SLOW)  : CNT_W'(ROM_WS_FAST);
  assign dram_ws   = dram_slow ? CNT_W'(DRAM_WS_SLOW) : CNT_W'(DRAM_WS_FAST);

  always_comb begin
    target = TGT_NONE;
    waits  = CNT_W'(IO_WS);
    if (io) begin
      target = (addr == CTRL_ADDR) ? TGT_CTRL : TGT_NONE;
      waits  = CNT_W'(IO_WS);
    end else if (!in_window) begin
      target = TGT_DRAM;
      waits  = dram_ws;
    end else if (write) begin
      // the ROM never sees a write; the hidden DRAM does when unprotected
      target = shadow_we ? TGT_DRAM : TGT_NONE;
      waits  = dram_ws;
    end else if (shadow_sel) begin
      target = TGT_DRAM;
      waits  = dram_ws;
    end else begin
      target = TGT_ROM;
      waits  = rom_ws;
    end
  end
endmodule

// File: rtl/bw_wait_timer.sv
`timescale 1ns/1ps
module bw_wait_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= load_val;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = busy && (cnt_q == '0);

  AST_LAST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last); // R8
endmodule

// File: rtl/bw_ctrl_reg.sv
`timescale 1ns/1ps
module bw_ctrl_reg
  import bw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTRL_BITS-1:0] wdata,
  output logic                 shadow_sel,
  output logic                 shadow_we
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_sel <= 1'b0;
      shadow_we  <= 1'b1;
    end else if (wr_en) begin
      shadow_sel <= wdata[0];
      shadow_we  <= wdata[1];
    end
  end

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({shadow_sel, shadow_we})); // R7
endmodule

// File: rtl/bootwin_decoder.sv
`timescale 1ns/1ps
module bootwin_decoder
  import bw_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int WIN_TAG_W = 4,
  parameter logic [WIN_TAG_W-1:0] WIN_TAG = '1,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 20'h000F8,
  parameter int CNT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rom_slow,
  input  logic              cfg_dram_slow,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_io,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rom_sel,
  output logic              dram_sel,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int PAD_W = DATA_W - CTRL_BITS;

  bw_target_e       dec_tgt;
  logic [CNT_W-1:0] dec_waits;
  logic             dec_win;
  logic             shadow_sel, shadow_we;
  logic             busy, last, start;

  bw_target_e       tgt_q;
  logic             write_q, win_q, io_q;
  logic [CNT_W-1:0] ws_q, age_q;

  bw_target_decode #(
    .ADDR_W(ADDR_W), .WIN_TAG_W(WIN_TAG_W), .WIN_TAG(WIN_TAG),
    .CTRL_ADDR(CTRL_ADDR), .CNT_W(CNT_W)
  ) i_decode (
    .io(req_io), .write(req_write), .addr(req_addr),
    .shadow_sel(shadow_sel), .shadow_we(shadow_we),
    .rom_slow(cfg_rom_slow), .dram_slow(cfg_dram_slow),
    .target(dec_tgt), .waits(dec_waits), .in_window(dec_win)
  );

  assign start = req_valid && !busy;

  bw_wait_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .load_val(dec_waits),
    .busy(busy), .last(last)
  );

  bw_ctrl_reg i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(last && write_q && (tgt_q == TGT_CTRL)),
    .wdata(req_wdata[CTRL_BITS-1:0]),
    .shadow_sel(shadow_sel), .shadow_we(shadow_we)
  );

  // access context captured at the start edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q   <= TGT_NONE;
      write_q <= 1'b0;
      win_q   <= 1'b0;
      io_q    <= 1'b0;
      ws_q    <= '0;
    end else if (start) begin
      tgt_q   <= dec_tgt;
      write_q <= req_write;
      win_q   <= dec_win;
      io_q    <= req_io;
      ws_q    <= dec_waits;
    end
  end

  // elapsed-cycle count, kept apart from the down-counter for checking
  always_ff @(posedge clk) begin
    if (!rst_n)              age_q <= '0;
    else if (start)          age_q <= '0;
    else if (busy && !last)  age_q <= age_q + 1'b1;
  end

  assign req_ready = last;
  assign rom_sel   = busy && (tgt_q == TGT_ROM);
  assign dram_sel  = busy && (tgt_q == TGT_DRAM);
  assign mem_we    = last && write_q && (tgt_q == TGT_DRAM);
  assign mem_wdata = req_wdata;

  always_comb begin
    rsp_rdata = '0;
    if (last && !write_q) begin
      case (tgt_q)
        TGT_CTRL: rsp_rdata = {{PAD_W{1'b0}}, shadow_we, shadow_sel};
        TGT_ROM,
        TGT_DRAM: rsp_rdata = mem_rdata;
        default:  rsp_rdata = '0;
      endcase
    end
  end

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && dram_sel)); // R4
  AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> !mem_we); // R2
  AST_ROM_ONLY_WHEN_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> !shadow_sel); // R4
  AST_STROBE_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (req_ready && dram_sel)); // R8
  AST_WINDOW_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && win_q) |-> shadow_we); // R6
  AST_OUTSIDE_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !win_q && !io_q) |-> dram_sel); // R3
  AST_WAIT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (age_q == ws_q)); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R9
endmodule

// File: tb/test_bootwin_decoder.sv
`timescale 1ns/1ps
module test_bootwin_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rom_slow = 1'b0, cfg_dram_slow = 1'b0;
  logic req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rom_sel, dram_sel, mem_we;
  logic [7:0] rsp_rdata, mem_wdata;
  logic [7:0] mem_rdata = '0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] dram_m [int];

  always #4 clk = ~clk;

  bootwin_decoder i_bootwin_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_rom_slow(cfg_rom_slow), .cfg_dram_slow(cfg_dram_slow),
    .req_valid(req_valid), .req_ready(req_ready), .req_io(req_io), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rom_sel(rom_sel), .dram_sel(dram_sel), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] rom_byte(logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] dram_rd(logic [19:0] a);
    if (dram_m.exists(int'(a))) return dram_m[int'(a)];
    return 8'hEE;
  endfunction

  // behavioural memory arrays
  always @(posedge clk) begin
    if (mem_we && dram_sel) dram_m[int'(req_addr)] = mem_wdata;
    #1;
    mem_rdata = rom_sel ? rom_byte(req_addr) : (dram_sel ? dram_rd(req_addr) : 8'h00);
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // tgt codes used by the bench: 0 none, 1 ROM, 2 DRAM
  task automatic access(string tag, bit io, bit wr, logic [19:0] a, logic [7:0] wd,
                        logic [7:0] exp_rd, int exp_ws, int exp_tgt, bit flip = 0);
    int cycles = 0, strobes = 0;
    bit done = 0, saw_rom = 0, saw_dram = 0, held_ok = 1;
    logic [7:0] rd = '0;
    @(negedge clk);
    req_valid = 1; req_io = io; req_write = wr; req_addr = a; req_wdata = wd;
    while (!done && cycles < 20) begin
      @(negedge clk);
      cycles++;
      if (flip && cycles == 1) cfg_rom_slow = ~cfg_rom_slow;
      if (rom_sel) saw_rom = 1;
      if (dram_sel) saw_dram = 1;
      if ((exp_tgt == 1 && !rom_sel) || (exp_tgt == 2 && !dram_sel)) held_ok = 0;
      if (mem_we) strobes++;
      if (req_ready) begin done = 1; rd = rsp_rdata; end
    end
    req_valid = 0;
    check({tag, " wait states R8"}, cycles - 1, exp_ws);
    check({tag, " rom_sel"}, saw_rom, exp_tgt == 1);
    check({tag, " dram_sel"}, saw_dram, exp_tgt == 2);
    check({tag, " select held R8"}, held_ok, 1);
    check({tag, " strobe count R9"}, strobes, (wr && exp_tgt == 2) ? 1 : 0);
    if (!wr) check({tag, " read data"}, rd, exp_rd);
    @(negedge clk);
    check({tag, " idle after ready R9"}, {rom_sel, dram_sel, req_ready}, 0);
  endtask

  task automatic ctrl_write(logic [1:0] v);
    access("R7 ctrl write", 1, 1, 20'h000F8, {6'b0, v}, 0, 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 outputs idle", {rom_sel, dram_sel, mem_we, req_ready}, 0);
    access("R1 ctrl reset value", 1, 0, 20'h000F8, 0, 8'h02, 0, 0);
  endtask

  task automatic t_rom_reads();
    cfg_rom_slow = 0;
    access("R2 rom fast", 0, 0, 20'hF1234, 0, rom_byte(20'hF1234), 2, 1);
    cfg_rom_slow = 1;
    access("R2 rom slow top", 0, 0, 20'hFFFFF, 0, rom_byte(20'hFFFFF), 3, 1);
    access("R2 rom slow base", 0, 0, 20'hF0000, 0, rom_byte(20'hF0000), 3, 1);
    cfg_dram_slow = 0;
    access("R3 below window", 0, 0, 20'hEFFFF, 0, 8'hEE, 0, 2);
  endtask

  task automatic t_low_dram();
    cfg_dram_slow = 0;
    access("R3 low write fast", 0, 1, 20'h00010, 8'h11, 0, 0, 2);
    access("R3 low read fast", 0, 0, 20'h00010, 0, 8'h11, 0, 2);
    cfg_dram_slow = 1;
    access("R3 low write slow", 0, 1, 20'h00011, 8'h22, 0, 1, 2);
    access("R3 low read slow", 0, 0, 20'h00011, 0, 8'h22, 1, 2);
    cfg_dram_slow = 0;
  endtask

  task automatic t_hidden_write();
    access("R5 window write sel0", 0, 1, 20'hF0020, 8'h77, 0, 0, 2);
    access("R2 rom still visible", 0, 0, 20'hF0020, 0, rom_byte(20'hF0020), 3, 1);
  endtask

  task automatic t_load_sequence();
    for (int k = 0; k < 4; k++) begin
      access("R2 load step1 rom read", 0, 0, 20'hF0000 + 20'(k), 0, rom_byte(20'hF0000 + 20'(k)), 3, 1);
      access("R3 load step1 low write", 0, 1, 20'h00100 + 20'(k), rom_byte(20'hF0000 + 20'(k)), 0, 0, 2);
    end
    ctrl_write(2'b11);
    access("R7 ctrl readback 3", 1, 0, 20'h000F8, 0, 8'h03, 0, 0);
    cfg_dram_slow = 1;
    for (int k = 0; k < 4; k++) begin
      access("R3 load step3 low read", 0, 0, 20'h00100 + 20'(k), 0, rom_byte(20'hF0000 + 20'(k)), 1, 2);
      access("R5 load step3 window write", 0, 1, 20'hF0000 + 20'(k), rom_byte(20'hF0000 + 20'(k)), 0, 1, 2);
    end
    ctrl_write(2'b01);
    access("R7 ctrl readback 1", 1, 0, 20'h000F8, 0, 8'h01, 0, 0);
    for (int k = 0; k < 4; k++)
      access("R4 shadow read", 0, 0, 20'hF0000 + 20'(k), 0, rom_byte(20'hF0000 + 20'(k)), 1, 2);
    access("R5 hidden write landed", 0, 0, 20'hF0020, 0, 8'h77, 1, 2);
    cfg_dram_slow = 0;
  endtask

  task automatic t_protect();
    access("R6 blocked write sel1", 0, 1, 20'hF0001, 8'h00, 0, 0, 0);
    access("R6 contents kept", 0, 0, 20'hF0001, 0, rom_byte(20'hF0001), 0, 2);
    ctrl_write(2'b00);
    cfg_dram_slow = 1;
    access("R6 blocked write sel0", 0, 1, 20'hF0002, 8'h00, 0, 1, 0);
    ctrl_write(2'b01);
    access("R6 contents kept sel0", 0, 0, 20'hF0002, 0, rom_byte(20'hF0002), 1, 2);
    cfg_dram_slow = 0;
  endtask

  task automatic t_io_other();
    access("R7 other io read", 1, 0, 20'h00080, 0, 8'h00, 0, 0);
    access("R7 other io write", 1, 1, 20'h00080, 8'h00, 0, 0, 0);
    access("R7 ctrl unchanged", 1, 0, 20'h000F8, 0, 8'h01, 0, 0);
  endtask

  task automatic t_cfg_sample();
    ctrl_write(2'b10);
    cfg_rom_slow = 0;
    access("R10 cfg change mid-access", 0, 0, 20'hF4321, 0, rom_byte(20'hF4321), 2, 1, 1);
    check("R10 cfg toggled", cfg_rom_slow, 1);
    access("R10 new cfg next access", 0, 0, 20'hF4321, 0, rom_byte(20'hF4321), 3, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rom_reads();
    t_low_dram();
    t_hidden_write();
    t_load_sequence();
    t_protect();
    t_io_other();
    t_cfg_sample();
    summary();
  end
endmodule